// File: doc/BRIEF.md
# Two-Stage Page Walk Translator

This block turns a 32-bit graphics virtual address into a physical address by reading a page directory entry and then a page table entry from memory. A client presents a directory base pointer together with the virtual address on a valid/ready request port. The walker fetches 64-bit words through a single-outstanding memory read port. It then reports either the translated physical address or a fault code that names the level at which the walk stopped.

The directory spans four adjacent 4 KiB pages. The two top address bits choose one of those pages, so the walker treats the directory as one flat array of 2048 entries. It never reads a separate top-level table. Each directory entry points at one table page of 512 entries, and each table entry maps one 4 KiB page. Bit 0 of every entry is its valid flag. The next-level base comes from entry bits 31:12. Entry bits 63:32 and 11:1 carry no meaning for the walk. Only one translation is in progress at any time, and nothing is cached between walks.

Top module: `gvw_walker`

## Requirements
- R1: The first memory read of a walk targets (req_dir_base with bits 11:0 cleared) + 8 × N, where N = vaddr[31:21], which equals vaddr[31:30] × 512 + vaddr[29:21].
- R2: If the directory entry has bit 0 set, the second read targets (entry bits 31:12 followed by twelve zero bits) + 8 × vaddr[20:12]. Entry bits 63:32 and 11:1 have no effect on this address.
- R3: If both entries have bit 0 set, the response carries rsp_fault = 0, rsp_fault_level = 0, and rsp_paddr = {table entry bits 31:12, vaddr[11:0]}.
- R4: If the directory entry has bit 0 clear, the walk issues exactly one memory read. It responds with rsp_fault = 1, rsp_fault_level = 1 and rsp_paddr = 0.
- R5: If the table entry has bit 0 clear, the walk issues exactly two memory reads. It responds with rsp_fault = 1, rsp_fault_level = 2 and rsp_paddr = 0.
- R6: req_ready is high only while the walker is idle. It goes low in the cycle after a request is accepted and stays low until the response.
- R7: rsp_valid is a one-cycle pulse per walk. rsp_paddr, rsp_fault and rsp_fault_level keep their values after the pulse until the next walk completes.
- R8: At most one memory read is outstanding. mem_req_valid and mem_req_addr stay stable while mem_req_ready is low. The walker waits any number of cycles for mem_rsp_valid.
- R9: After reset, req_ready = 1, rsp_valid = 0, mem_req_valid = 0 and rsp_fault_level = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted on this cycle |
| req_dir_base | input | 32 | Directory base pointer (low 12 bits ignored) |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Entry word returned by memory |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_paddr | output | 32 | Translated physical address (0 on fault) |
| rsp_fault | output | 1 | Walk failed |
| rsp_fault_level | output | 2 | 0 none, 1 directory entry invalid, 2 table entry invalid |

## Verification
The assertions assume the memory side is well behaved. It raises mem_rsp_valid only once per accepted read, and only after that read has been accepted. The bench responder follows this rule: it holds a single pending read, waits between zero and three cycles before answering, and varies mem_req_ready in a pattern that stalls some requests. Requests are issued only while req_ready is high and are removed right after acceptance. The client side therefore never drives a request into a busy walker.

// File: rtl/gvw_pkg.sv
// Shared types for the page walk translator.
// Assumes: entries are 64-bit words, pages are 4 KiB.
package gvw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_TBL_REQ,
        ST_TBL_WAIT
    } walk_state_t;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_DIR  = 2'd1,
        LVL_TBL  = 2'd2
    } fault_lvl_t;
endpackage

// File: rtl/gvw_index_calc.sv
// Entry address generator: forms the byte address of the directory
// entry and of the table entry from the bases and the virtual address.
// Assumes: directory pages are contiguous, so the top selector bits and
// the directory index together form one flat index.
module gvw_index_calc #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 9,
    parameter int SEL_W      = 2
) (
    input  logic [ADDR_W-1:0] dir_base,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-1:0] tbl_base,
    output logic [ADDR_W-1:0] dir_ent_addr,
    output logic [ADDR_W-1:0] tbl_ent_addr
);
    localparam int ENT_SHIFT = 3;
    localparam int DIR_IDX_W = SEL_W + IDX_W;
    localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1));

    logic [DIR_IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0]     tbl_idx;

    // Split the virtual address into flat directory index and table index.
    always_comb begin
        dir_idx = vaddr[ADDR_W-1 -: DIR_IDX_W];
        tbl_idx = vaddr[PAGE_SHIFT +: IDX_W];
    end

    // Scale each index by the entry size and add the page-aligned base.
    always_comb begin
        dir_ent_addr = (dir_base & PAGE_MASK)
                     + {{(ADDR_W-DIR_IDX_W-ENT_SHIFT){1'b0}}, dir_idx, {ENT_SHIFT{1'b0}}};
        tbl_ent_addr = (tbl_base & PAGE_MASK)
                     + {{(ADDR_W-IDX_W-ENT_SHIFT){1'b0}}, tbl_idx, {ENT_SHIFT{1'b0}}};
    end

    logic unused_vaddr;
    assign unused_vaddr = ^{vaddr[PAGE_SHIFT-1:0], vaddr[ADDR_W-DIR_IDX_W-1 -: (ADDR_W-DIR_IDX_W-PAGE_SHIFT-IDX_W+IDX_W)] & 1'b0};
endmodule

// File: rtl/gvw_entry_decode.sv
// Entry decoder: pulls the valid flag and the page-aligned next-level
// base out of a 64-bit directory or table entry.
// Assumes: only bit 0 and bits ADDR_W-1:PAGE_SHIFT carry meaning.
module gvw_entry_decode #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [DATA_W-1:0] entry,
    output logic              ent_valid,
    output logic [ADDR_W-1:0] ent_base
);
    // Take the flag and the frame number, clearing the in-page bits.
    always_comb begin
        ent_valid = entry[0];
        ent_base  = {entry[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    end

    logic unused_bits;
    assign unused_bits = ^{entry[DATA_W-1:ADDR_W], entry[PAGE_SHIFT-1:1]};
endmodule

// File: rtl/gvw_walker.sv
// Page walk translator top: accepts one request, reads the directory
// entry, then the table entry, and reports an address or a fault level.
// Assumes: memory answers each accepted read exactly once, in order.
module gvw_walker
    import gvw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 9,
    parameter int SEL_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_dir_base,
    input  logic [ADDR_W-1:0] req_vaddr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_fault,
    output logic [1:0]        rsp_fault_level
);
    walk_state_t       state;
    logic [ADDR_W-1:0] vaddr_q, dir_base_q, tbl_base_q, paddr_q;
    logic              fault_q, rsp_valid_q;
    fault_lvl_t        level_q;
    logic [ADDR_W-1:0] dir_ent_addr, tbl_ent_addr, ent_base, page_off;
    logic              ent_valid;

    gvw_index_calc #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W), .SEL_W(SEL_W)
    ) u_index (
        .dir_base(dir_base_q), .vaddr(vaddr_q), .tbl_base(tbl_base_q),
        .dir_ent_addr(dir_ent_addr), .tbl_ent_addr(tbl_ent_addr)
    );

    gvw_entry_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_decode (
        .entry(mem_rsp_data), .ent_valid(ent_valid), .ent_base(ent_base)
    );

    // In-page offset carried through to the physical address.
    always_comb page_off = {{(ADDR_W-PAGE_SHIFT){1'b0}}, vaddr_q[PAGE_SHIFT-1:0]};

    // Port outputs derived from the walk state.
    always_comb begin
        req_ready       = (state == ST_IDLE);
        mem_req_valid   = (state == ST_DIR_REQ) || (state == ST_TBL_REQ);
        mem_req_addr    = (state == ST_TBL_REQ) ? tbl_ent_addr : dir_ent_addr;
        rsp_valid       = rsp_valid_q;
        rsp_paddr       = paddr_q;
        rsp_fault       = fault_q;
        rsp_fault_level = level_q;
    end

    // Walk sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            vaddr_q     <= '0;
            dir_base_q  <= '0;
            tbl_base_q  <= '0;
            paddr_q     <= '0;
            fault_q     <= 1'b0;
            level_q     <= LVL_NONE;
            rsp_valid_q <= 1'b0;
        end else begin
            rsp_valid_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    vaddr_q    <= req_vaddr;
                    dir_base_q <= req_dir_base;
                    state      <= ST_DIR_REQ;
                end
                ST_DIR_REQ: if (mem_req_ready) state <= ST_DIR_WAIT;
                ST_DIR_WAIT: if (mem_rsp_valid) begin
                    if (!ent_valid) begin
                        paddr_q     <= '0;
                        fault_q     <= 1'b1;
                        level_q     <= LVL_DIR;
                        rsp_valid_q <= 1'b1;
                        state       <= ST_IDLE;
                    end else begin
                        tbl_base_q <= ent_base;
                        state      <= ST_TBL_REQ;
                    end
                end
                ST_TBL_REQ: if (mem_req_ready) state <= ST_TBL_WAIT;
                ST_TBL_WAIT: if (mem_rsp_valid) begin
                    paddr_q     <= ent_valid ? (ent_base | page_off) : '0;
                    fault_q     <= !ent_valid;
                    level_q     <= ent_valid ? LVL_NONE : LVL_TBL;
                    rsp_valid_q <= 1'b1;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: an invalid directory entry ends the walk with level 1 next cycle.
    a_r4_dir_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIR_WAIT && mem_rsp_valid && !mem_rsp_data[0])
        |=> (rsp_valid && rsp_fault_level == 2'd1 && !mem_req_valid));

    // R5: an invalid table entry ends the walk with level 2 next cycle.
    a_r5_tbl_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TBL_WAIT && mem_rsp_valid && !mem_rsp_data[0])
        |=> (rsp_valid && rsp_fault_level == 2'd2 && rsp_fault));

    // R6: acceptance makes the walker busy on the next cycle.
    a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7: completion is a single-cycle pulse.
    a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7: results hold while no completion is signalled.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ($stable(rsp_paddr) && $stable(rsp_fault_level)));

    // R8: a stalled read keeps its request and address.
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R8: no second read is issued right behind an accepted one.
    a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
endmodule

// File: tb/gvw_walker_tb.sv
module gvw_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_dir_base = '0;
    logic [31:0] req_vaddr = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_fault_level;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int rd_total = 0;
    int overlap_err = 0;
    logic [31:0] addr_log [0:3];
    logic        pending = 1'b0;
    int          lat_cnt = 0;
    logic [31:0] pend_addr = '0;

    localparam logic [31:0] DIR_REGION = 32'h0010_0000;
    localparam logic [31:0] TBL_REGION = 32'h0080_0000;

    gvw_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_dir_base(req_dir_base), .req_vaddr(req_vaddr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_fault_level(rsp_fault_level)
    );

    always #2 clk = ~clk;

    // Memory image: directory words and table words with junk in ignored bits.
    function automatic logic [63:0] mem_word(input logic [31:0] a);
        logic [31:0] idx, lo, hi;
        if (a >= DIR_REGION && a < DIR_REGION + 32'h4000) begin
            idx = (a - DIR_REGION) >> 3;
            lo  = (TBL_REGION + idx * 32'h1000) | ((idx << 1) & 32'hFFE)
                | ((idx % 5 != 3) ? 32'd1 : 32'd0);
            hi  = 32'hDEAD_0000 | idx;
        end else begin
            idx = a >> 3;
            lo  = (((idx * 13 + 7) & 32'hFFFFF) << 12) | 32'hA5A
                | ((idx % 7 != 2) ? 32'd1 : 32'd0);
            lo[0] = (idx % 7 != 2);
            hi  = 32'hBEEF_0000 ^ a;
        end
        return {hi, lo};
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Single-outstanding memory responder with stalls and variable latency.
    always @(negedge clk) begin
        logic rdy;
        if (mem_rsp_valid) mem_rsp_valid = 1'b0;
        if (pending) begin
            if (mem_req_valid) overlap_err = overlap_err + 1;
            if (lat_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_word(pend_addr);
                pending       = 1'b0;
            end else lat_cnt = lat_cnt - 1;
        end
        rdy = rst_n && (cycles % 3 != 1);
        mem_req_ready = rdy;
        if (mem_req_valid && rdy && !pending) begin
            pend_addr = mem_req_addr;
            addr_log[rd_total % 4] = mem_req_addr;
            lat_cnt = rd_total % 4;
            rd_total = rd_total + 1;
            pending = 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] base, input logic [31:0] va);
        logic [31:0] d_addr, t_addr, e_pa;
        logic [63:0] dw, tw;
        logic [1:0]  e_lvl;
        int e_reads, start, n;
        d_addr = DIR_REGION + ({21'd0, va[31:21]} << 3);
        dw = mem_word(d_addr);
        t_addr = 32'h0; e_pa = 32'h0;
        if (!dw[0]) begin e_lvl = 2'd1; e_reads = 1; end
        else begin
            t_addr = (dw[31:0] & 32'hFFFFF000) + ({23'd0, va[20:12]} << 3);
            tw = mem_word(t_addr);
            e_reads = 2;
            if (!tw[0]) e_lvl = 2'd2;
            else begin e_lvl = 2'd0; e_pa = {tw[31:12], va[11:0]}; end
        end
        start = rd_total;
        @(negedge clk);
        req_valid = 1'b1; req_dir_base = base; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = ~va;
        check(req_ready == 1'b0, "R6", {63'd0, req_ready}, 64'd0);
        n = 0;
        while (!rsp_valid && n < 200) begin @(negedge clk); n = n + 1; end
        check(rsp_valid == 1'b1, "R8", {63'd0, rsp_valid}, 64'd1);
        check(rd_total - start == e_reads, (e_lvl == 2'd1) ? "R4" : "R5",
              64'(rd_total - start), 64'(e_reads));
        check(addr_log[start % 4] == d_addr, "R1", {32'd0, addr_log[start % 4]}, {32'd0, d_addr});
        if (e_reads == 2)
            check(addr_log[(start + 1) % 4] == t_addr, "R2",
                  {32'd0, addr_log[(start + 1) % 4]}, {32'd0, t_addr});
        check(rsp_fault_level == e_lvl && rsp_fault == (e_lvl != 2'd0),
              (e_lvl == 2'd0) ? "R3" : ((e_lvl == 2'd1) ? "R4" : "R5"),
              {61'd0, rsp_fault, rsp_fault_level}, {61'd0, (e_lvl != 2'd0), e_lvl});
        check(rsp_paddr == e_pa, (e_lvl == 2'd0) ? "R3" : "R5",
              {32'd0, rsp_paddr}, {32'd0, e_pa});
        @(negedge clk);
        check(rsp_valid == 1'b0 && rsp_paddr == e_pa && rsp_fault_level == e_lvl, "R7",
              {31'd0, rsp_valid, rsp_paddr}, {32'd0, e_pa});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0 && rsp_fault_level == 2'd0,
              "R9", {60'd0, req_ready, rsp_valid, mem_req_valid, |rsp_fault_level}, 64'h8);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R6", {63'd0, req_ready}, 64'd1);
        for (int s = 0; s < 4; s++) begin
            for (int di = 0; di < 5; di++) begin
                for (int ti = 0; ti < 3; ti++) begin
                    logic [8:0]  dsel, tsel;
                    logic [11:0] off;
                    dsel = (di == 0) ? 9'd0 : (di == 1) ? 9'd3 : (di == 2) ? 9'd8 : (di == 3) ? 9'd255 : 9'd511;
                    tsel = (ti == 0) ? 9'd0 : (ti == 1) ? 9'd2 : 9'd511;
                    off  = 12'(s * 1000 + di * 77 + ti * 5);
                    walk(DIR_REGION | 32'(12'h0AB + s), {s[1:0], dsel, tsel, off});
                end
            end
        end
        for (int k = 0; k < 40; k++) begin
            walk(DIR_REGION | 32'hFFF, 32'(k) * 32'h0134_5679 + 32'h89);
        end
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0 && req_ready == 1'b1, "R7", {62'd0, rsp_valid, req_ready}, 64'd1);
        check(overlap_err == 0, "R8", 64'(overlap_err), 64'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule